// File: doc/BRIEF.md
# Compressed Audio Burst Detector

This block sits behind the subframe decoder of a consumer digital audio receiver and inspects the 16-bit payload words it delivers. It looks for the six-word start-of-burst pattern that marks a compressed (non-PCM) stream. When it finds the pattern, it raises a sticky flag and stores the two descriptor words that come right after the pattern: the burst information word and the length code word. A second matcher spots a DTS-CD stream carried as 14-bit words and raises its own sticky flag.

Each flag is held by a frame counter. The counter advances on every frame-start strobe and restarts whenever its matcher sees a fresh sync. A flag drops once a full window of frames passes with no new sync. A combined output reports that either kind of compressed stream is present, so the surrounding logic can mute or reroute the PCM path.

Reset is synchronous and active low.

Top module: `nonpcm_burst_detect`

## Requirements
- R1: While `rst_n` is low at a clock edge, that edge clears `npcm_flag`, `dts14_flag`, `auto_flag`, `burst_info` and `burst_len` to 0.
- R2: Valid words 0x0000, 0x0000, 0x0000, 0x0000, 0xF872 and 0x4E1F, arriving in that order, set `npcm_flag` to 1. The flag is visible from the clock edge that samples the last word.
- R3: A word that breaks the sequence restarts the matcher. A breaking word of 0x0000 still counts as a leading zero. A run of more than four zeros before 0xF872 therefore still matches, while a run of three zeros, or a wrong word after 0xF872, does not.
- R4: After a match, the next valid word is stored in `burst_info` and the valid word after that is stored in `burst_len`.
- R5: With no new match, `npcm_flag` stays at 1 through 4095 frame-start strobes after the match and clears on the 4096th strobe.
- R6: A new match while a flag is set restarts that flag's 4096-frame window from zero.
- R7: Valid words 0x1FFF, then 0xE800, then a word whose upper 12 bits are 0x07F set `dts14_flag` to 1. The flag follows the same 4096-frame hold and clear rule as `npcm_flag`.
- R8: The 16-bit DTS sync words 0x7FFE followed by 0x8001 do not set `dts14_flag`. A third word whose upper 12 bits differ from 0x07F does not set it either.
- R9: `auto_flag` equals `npcm_flag` OR `dts14_flag`.
- R10: The block ignores `word_data` on any cycle where `word_valid` is low. Such cycles neither advance the matchers nor change `burst_info` or `burst_len`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| word_valid | input | 1 | `word_data` holds one subframe payload word |
| word_data | input | 16 | Subframe payload word |
| frame_start | input | 1 | One-cycle strobe at the start of each frame |
| npcm_flag | output | 1 | Non-PCM burst stream present |
| dts14_flag | output | 1 | 14-bit DTS-CD stream present |
| auto_flag | output | 1 | Either compressed stream present |
| burst_info | output | 16 | Burst information word captured after the last sync |
| burst_len | output | 16 | Length code word captured after the last sync |

## Verification
A matcher stuck partway through the pattern shows up at once. Either the flag fails to rise on the edge after the final sync word, or it rises on a pattern that should have been rejected. A capture state that is out of step puts the wrong word into `burst_info` or `burst_len`, and this is visible one cycle after the descriptor words.

A hold counter that is off by one can only be seen at the edge of the window: one frame-start early or late, after 4095 or 4096 strobes. The tests probe exactly those two points, both after a first sync and after a mid-window retrigger.

// File: rtl/burst_det_pkg.sv
// Package: shared constants, state type and pattern lookups for the
// compressed audio burst detector. Assumes 16-bit subframe payload words.
package burst_det_pkg;

    localparam int WORD_W   = 16;
    localparam int SYNC_LEN = 6;
    localparam int ZERO_RUN = 4;
    localparam int DTS_LEN  = 3;

    localparam logic [WORD_W-1:0] SYNC_HI = 16'hF872;
    localparam logic [WORD_W-1:0] SYNC_LO = 16'h4E1F;

    localparam logic [WORD_W-1:0] DTS_W0 = 16'h1FFF;
    localparam logic [WORD_W-1:0] DTS_W1 = 16'hE800;
    localparam logic [WORD_W-1:0] DTS_W2 = 16'h07F0;
    localparam logic [WORD_W-1:0] DTS_M2 = 16'hFFF0;

    typedef enum logic [1:0] {
        CAP_IDLE = 2'd0,
        CAP_INFO = 2'd1,
        CAP_LEN  = 2'd2
    } cap_state_e;

    // Expected burst sync word at a given position in the sequence
    function automatic logic [WORD_W-1:0] burst_sync_word(input logic [2:0] idx);
        case (idx)
            3'd4:    burst_sync_word = SYNC_HI;
            3'd5:    burst_sync_word = SYNC_LO;
            default: burst_sync_word = '0;
        endcase
    endfunction

    // True when a word matches the 14-bit DTS pattern at a given position
    function automatic logic dts_word_ok(input logic [1:0] idx, input logic [WORD_W-1:0] w);
        case (idx)
            2'd0:    dts_word_ok = (w == DTS_W0);
            2'd1:    dts_word_ok = (w == DTS_W1);
            default: dts_word_ok = ((w & DTS_M2) == DTS_W2);
        endcase
    endfunction

endpackage

// File: rtl/burst_sync_matcher.sv
// Finds the six-word compressed-burst sync sequence in the valid word
// stream and captures the two descriptor words that follow it.
// Assumes at most one word per cycle; sync_hit is a combinational pulse
// in the cycle the final sync word is presented.
module burst_sync_matcher
    import burst_det_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_valid,
    input  logic [WORD_W-1:0] word_data,
    output logic              sync_hit,
    output logic [WORD_W-1:0] info_word,
    output logic [WORD_W-1:0] len_word
);

    localparam int CNT_W = $clog2(SYNC_LEN);

    logic [CNT_W-1:0] match_cnt;
    cap_state_e       cap_st;
    logic             word_match;
    logic             last_pos;

    // Compare the incoming word against the expected sync word
    always_comb begin
        word_match = word_valid && (cap_st == CAP_IDLE) &&
                     (word_data == burst_sync_word(3'(match_cnt)));
        last_pos   = (match_cnt == CNT_W'(SYNC_LEN - 1));
        sync_hit   = word_match && last_pos;
    end

    // Advance or restart the sequence position, and capture descriptor words
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            match_cnt <= '0;
            cap_st    <= CAP_IDLE;
            info_word <= '0;
            len_word  <= '0;
        end else if (word_valid) begin
            case (cap_st)
                CAP_IDLE: begin
                    if (word_match) begin
                        if (last_pos) begin
                            match_cnt <= '0;
                            cap_st    <= CAP_INFO;
                        end else begin
                            match_cnt <= match_cnt + 1'b1;
                        end
                    end else if (word_data == '0) begin
                        match_cnt <= (match_cnt == CNT_W'(ZERO_RUN)) ? match_cnt : CNT_W'(1);
                    end else begin
                        match_cnt <= '0;
                    end
                end
                CAP_INFO: begin
                    info_word <= word_data;
                    cap_st    <= CAP_LEN;
                end
                default: begin
                    len_word <= word_data;
                    cap_st   <= CAP_IDLE;
                end
            endcase
        end
    end

endmodule

// File: rtl/dts14_matcher.sv
// Finds the three-word 14-bit DTS-CD sync pattern in the valid word stream.
// The last word is compared on its upper bits only. sync_hit is a
// combinational pulse in the cycle the final pattern word is presented.
module dts14_matcher
    import burst_det_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_valid,
    input  logic [WORD_W-1:0] word_data,
    output logic              sync_hit
);

    localparam int CNT_W = $clog2(DTS_LEN);

    logic [CNT_W-1:0] pos;
    logic             pos_ok;
    logic             restart_ok;

    // Evaluate the word at the current position and as a fresh start
    always_comb begin
        pos_ok     = dts_word_ok(2'(pos), word_data);
        restart_ok = dts_word_ok(2'd0, word_data);
        sync_hit   = word_valid && pos_ok && (pos == CNT_W'(DTS_LEN - 1));
    end

    // Track the position within the pattern
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos <= '0;
        end else if (word_valid) begin
            if (sync_hit)
                pos <= '0;
            else if (pos_ok)
                pos <= pos + 1'b1;
            else if (restart_ok)
                pos <= CNT_W'(1);
            else
                pos <= '0;
        end
    end

endmodule

// File: rtl/flag_hold_timer.sv
// Sticky flag with a retriggerable frame window. A hit sets the flag and
// restarts the count. Each frame strobe advances the count, and the
// FRAME_LIMIT-th strobe without a hit clears the flag. A hit wins over a
// strobe in the same cycle.
module flag_hold_timer #(
    parameter int FRAME_LIMIT = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic frame_tick,
    output logic flag
);

    localparam int CW = (FRAME_LIMIT > 1) ? $clog2(FRAME_LIMIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(FRAME_LIMIT - 1);

    logic [CW-1:0] frames;

    // Set, hold and time out the flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag   <= 1'b0;
            frames <= '0;
        end else if (hit) begin
            flag   <= 1'b1;
            frames <= '0;
        end else if (flag && frame_tick) begin
            if (frames == LAST) begin
                flag   <= 1'b0;
                frames <= '0;
            end else begin
                frames <= frames + 1'b1;
            end
        end
    end

endmodule

// File: rtl/nonpcm_burst_detect.sv
// Top level of the compressed audio burst detector. It joins the burst
// sync matcher, the 14-bit DTS matcher and one hold timer per flag.
// Assumes word_valid and frame_start come from the subframe decoder in
// the clk domain.
module nonpcm_burst_detect
    import burst_det_pkg::*;
#(
    parameter int FRAME_LIMIT = 4096
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        word_valid,
    input  logic [15:0] word_data,
    input  logic        frame_start,
    output logic        npcm_flag,
    output logic        dts14_flag,
    output logic        auto_flag,
    output logic [15:0] burst_info,
    output logic [15:0] burst_len
);

    localparam int N_FLAGS = 2;

    logic [N_FLAGS-1:0] hits;
    logic [N_FLAGS-1:0] flags;

    burst_sync_matcher u_burst (
        .clk        (clk),
        .rst_n      (rst_n),
        .word_valid (word_valid),
        .word_data  (word_data),
        .sync_hit   (hits[0]),
        .info_word  (burst_info),
        .len_word   (burst_len)
    );

    dts14_matcher u_dts (
        .clk        (clk),
        .rst_n      (rst_n),
        .word_valid (word_valid),
        .word_data  (word_data),
        .sync_hit   (hits[1])
    );

    // One hold timer per detected stream type
    for (genvar g = 0; g < N_FLAGS; g++) begin : g_hold
        flag_hold_timer #(.FRAME_LIMIT(FRAME_LIMIT)) u_hold (
            .clk        (clk),
            .rst_n      (rst_n),
            .hit        (hits[g]),
            .frame_tick (frame_start),
            .flag       (flags[g])
        );
    end

    // Drive the flag outputs
    always_comb begin
        npcm_flag  = flags[0];
        dts14_flag = flags[1];
        auto_flag  = |flags;
    end

endmodule

// File: rtl/burst_det_checker.sv
// Assertion checker for nonpcm_burst_detect, attached by bind below.
// Only the top-level ports are observed.
module burst_det_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        word_valid,
    input logic [15:0] word_data,
    input logic        frame_start,
    input logic        npcm_flag,
    input logic        dts14_flag,
    input logic        auto_flag,
    input logic [15:0] burst_info,
    input logic [15:0] burst_len
);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (!npcm_flag && !dts14_flag && burst_info == 16'h0 && burst_len == 16'h0));

    // R2
    npcm_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(npcm_flag) |-> $past(word_valid));

    // R5
    npcm_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(npcm_flag) && $past(rst_n)) |-> $past(frame_start));

    // R7
    dts_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dts14_flag) |-> $past(word_valid));

    // R7
    dts_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(dts14_flag) && $past(rst_n)) |-> $past(frame_start));

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(word_valid)) |-> ($stable(burst_info) && $stable(burst_len)));

    // R9
    auto_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (npcm_flag || dts14_flag) |-> auto_flag);

endmodule

bind nonpcm_burst_detect burst_det_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .word_valid  (word_valid),
    .word_data   (word_data),
    .frame_start (frame_start),
    .npcm_flag   (npcm_flag),
    .dts14_flag  (dts14_flag),
    .auto_flag   (auto_flag),
    .burst_info  (burst_info),
    .burst_len   (burst_len)
);

// File: tb/nonpcm_burst_detect_tb.sv
module nonpcm_burst_detect_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        word_valid = 1'b0;
    logic [15:0] word_data = '0;
    logic        frame_start = 1'b0;
    logic        npcm_flag, dts14_flag, auto_flag;
    logic [15:0] burst_info, burst_len;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    nonpcm_burst_detect u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .word_valid  (word_valid),
        .word_data   (word_data),
        .frame_start (frame_start),
        .npcm_flag   (npcm_flag),
        .dts14_flag  (dts14_flag),
        .auto_flag   (auto_flag),
        .burst_info  (burst_info),
        .burst_len   (burst_len)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; word_valid = 1'b0; frame_start = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic send_word(input logic [15:0] w);
        @(negedge clk);
        word_valid = 1'b1; word_data = w;
        @(negedge clk);
        word_valid = 1'b0; word_data = 16'hDEAD;
    endtask

    task automatic frames(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            frame_start = 1'b1;
            @(negedge clk);
            frame_start = 1'b0;
        end
    endtask

    task automatic send_sync();
        for (int i = 0; i < 4; i++) send_word(16'h0000);
        send_word(16'hF872);
        send_word(16'h4E1F);
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 npcm", {15'd0, npcm_flag}, 16'd0);
        check("R1 dts", {15'd0, dts14_flag}, 16'd0);
        check("R1 auto", {15'd0, auto_flag}, 16'd0);
        check("R1 info", burst_info, 16'h0000);
        check("R1 len", burst_len, 16'h0000);
    endtask

    task automatic t_basic_capture();
        do_reset();
        for (int i = 0; i < 4; i++) send_word(16'h0000);
        send_word(16'hF872);
        check("R2 before last word", {15'd0, npcm_flag}, 16'd0);
        send_word(16'h4E1F);
        check("R2 set", {15'd0, npcm_flag}, 16'd1);
        check("R9 auto from npcm", {15'd0, auto_flag}, 16'd1);
        // R10: invalid cycle with data present must not be captured
        @(negedge clk); word_data = 16'hBEEF;
        @(negedge clk);
        check("R10 info untouched", burst_info, 16'h0000);
        send_word(16'h0015);
        check("R4 info", burst_info, 16'h0015);
        send_word(16'h1A00);
        check("R4 len", burst_len, 16'h1A00);
        check("R4 info held", burst_info, 16'h0015);
    endtask

    task automatic t_restart_rules();
        do_reset();
        for (int i = 0; i < 3; i++) send_word(16'h0000);
        send_word(16'hF872);
        send_word(16'h4E1F);
        check("R3 three zeros", {15'd0, npcm_flag}, 16'd0);
        for (int i = 0; i < 4; i++) send_word(16'h0000);
        send_word(16'hF872);
        send_word(16'h1234);
        check("R3 bad tail", {15'd0, npcm_flag}, 16'd0);
        for (int i = 0; i < 7; i++) send_word(16'h0000);
        send_word(16'hF872);
        send_word(16'h4E1F);
        check("R3 long zero run", {15'd0, npcm_flag}, 16'd1);
    endtask

    task automatic t_timeout();
        do_reset();
        send_sync();
        send_word(16'h0003);
        send_word(16'h0800);
        frames(4095);
        check("R5 held 4095", {15'd0, npcm_flag}, 16'd1);
        frames(1);
        check("R5 cleared 4096", {15'd0, npcm_flag}, 16'd0);
        check("R9 auto cleared", {15'd0, auto_flag}, 16'd0);
    endtask

    task automatic t_retrigger();
        do_reset();
        send_sync();
        send_word(16'h0001);
        send_word(16'h0002);
        frames(3000);
        send_sync();
        send_word(16'h0007);
        send_word(16'h0040);
        check("R4 recapture info", burst_info, 16'h0007);
        check("R4 recapture len", burst_len, 16'h0040);
        frames(4095);
        check("R6 held after retrigger", {15'd0, npcm_flag}, 16'd1);
        frames(1);
        check("R6 cleared", {15'd0, npcm_flag}, 16'd0);
    endtask

    task automatic t_dts();
        do_reset();
        send_word(16'h7FFE); send_word(16'h8001);
        send_word(16'h7FFE); send_word(16'h8001);
        check("R8 16-bit sync", {15'd0, dts14_flag}, 16'd0);
        send_word(16'h1FFF); send_word(16'hE800); send_word(16'h07E5);
        check("R8 wrong third word", {15'd0, dts14_flag}, 16'd0);
        send_word(16'h1FFF); send_word(16'hE800); send_word(16'h07F3);
        check("R7 set", {15'd0, dts14_flag}, 16'd1);
        check("R9 auto from dts", {15'd0, auto_flag}, 16'd1);
        check("R7 npcm untouched", {15'd0, npcm_flag}, 16'd0);
        frames(4095);
        check("R7 held 4095", {15'd0, dts14_flag}, 16'd1);
        frames(1);
        check("R7 cleared", {15'd0, dts14_flag}, 16'd0);
        check("R9 auto off", {15'd0, auto_flag}, 16'd0);
    endtask

    initial begin
        t_reset();
        t_basic_capture();
        t_restart_rules();
        t_timeout();
        t_retrigger();
        t_dts();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule